// File: doc/BRIEF.md
# Receive DMA Completion-Pointer Interrupt Acknowledge

The block keeps one completion pointer and one interrupt line for each receive DMA channel. When the DMA engine retires a buffer descriptor, it presents the channel number and that descriptor's address on its update port. The block stores the address and raises the channel's interrupt on the next clock edge.

The host services the channel and then writes back the address of the last descriptor it handled. That write is never stored. The block only compares it with the address the DMA recorded. The interrupt drops when the two are equal and stays up when they differ, so a host that is behind the DMA keeps getting interrupted.

Host reads always return the DMA-recorded address. Each channel's pointer sits at its own aligned 32-bit word, at byte offset four times the channel number.

Top module: `cpl_ack_unit`

## Requirements
- R1: After reset every channel's pointer reads as 0 and every bit of `irq_o` is 0.
- R2: A DMA update (`dma_upd_i`=1) stores `dma_ptr_i` into channel `dma_ch_i`. A host read at byte offset 4*channel then returns that value, and the other channels keep their values.
- R3: A host write (`host_we_i`=1) never changes any stored pointer.
- R4: A host write to a channel whose interrupt is pending, with a value equal to its stored pointer, clears that channel's `irq_o` bit at the next clock edge.
- R5: A host write with a value different from the stored pointer leaves that channel's `irq_o` bit asserted.
- R6: A DMA update sets the addressed channel's `irq_o` bit at the next clock edge. `irq_o` comes straight from a register.
- R7: When a DMA update and a host write hit the same channel in one cycle, the DMA update wins. The bit stays set and the pointer takes the new DMA value.
- R8: A host write to a channel with no pending interrupt has no effect: the `irq_o` bit stays 0 and the pointer is unchanged.
- R9: A host access is decoded only when `host_addr_i[1:0]` is 0 and the word index `host_addr_i[HOST_AW-1:2]` is below NUM_CH. Any other write is ignored, and any other read returns 0.
- R10: An acknowledge affects only the addressed channel, even when another pending channel holds the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_upd_i | input | 1 | DMA completion update strobe |
| dma_ch_i | input | CH_W | Channel of the DMA update |
| dma_ptr_i | input | PTR_W | Address of the last completed descriptor |
| host_we_i | input | 1 | Host acknowledge write strobe |
| host_addr_i | input | HOST_AW | Host byte address |
| host_wdata_i | input | PTR_W | Host acknowledge value |
| host_rdata_o | output | PTR_W | Pointer at `host_addr_i` (combinational) |
| irq_o | output | NUM_CH | Per-channel interrupt, registered |

## Verification
A stale or corrupted pointer shows up in two ways. The host read at that channel's offset returns the wrong value on the cycle after the update. A later acknowledge with the correct address then fails to clear the interrupt at the next edge. A wrong pending flag appears on `irq_o` one edge after the update or acknowledge that should have set or cleared it. A decode fault shows up as a change on a neighbouring channel's read value or interrupt bit.

// File: rtl/cpl_ack_pkg.sv
package cpl_ack_pkg;
  localparam int unsigned PTR_W = 32;
  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/cpl_addr_dec.sv
module cpl_addr_dec #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned HOST_AW = 7
) (
  input  logic [HOST_AW-1:0] addr_i,
  output logic [NUM_CH-1:0]  sel_o
);
  localparam int unsigned IDX_W = HOST_AW - 2;
  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr_i[HOST_AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign sel_o[c] = aligned && (idx == IDX_W'(c));
  end
endmodule

// File: rtl/cpl_chan.sv
module cpl_chan
  import cpl_ack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_hit_i,
  input  ptr_t dma_ptr_i,
  input  logic ack_hit_i,
  input  ptr_t ack_val_i,
  output ptr_t ptr_o,
  output logic irq_o
);
  ptr_t ptr_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (dma_hit_i) begin
      ptr_q  <= dma_ptr_i;
      pend_q <= 1'b1;  // DMA wins over a same-cycle acknowledge
    end else if (ack_hit_i && pend_q && (ack_val_i == ptr_q)) begin
      pend_q <= 1'b0;
    end
  end

  assign ptr_o = ptr_q;
  assign irq_o = pend_q;

  AST_UPD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hit_i |=> (irq_o && ptr_o == $past(dma_ptr_i))); // R6
  AST_ACK_NOSTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_hit_i |=> $stable(ptr_o)); // R3
  AST_MATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_hit_i && !dma_hit_i && ack_val_i == ptr_o) |=> !irq_o); // R4
  AST_MISMATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_hit_i && ack_val_i != ptr_o) |=> irq_o); // R5
  AST_DMA_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_hit_i && ack_hit_i) |=> irq_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !dma_hit_i) |=> !irq_o); // R8
endmodule

// File: rtl/cpl_rd_mux.sv
module cpl_rd_mux
  import cpl_ack_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] sel_i,
  input  ptr_t              ptr_i [NUM_CH],
  output ptr_t              rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_i[c]) rdata_o = rdata_o | ptr_i[c];
    end
  end
endmodule

// File: rtl/cpl_ack_unit.sv
module cpl_ack_unit
  import cpl_ack_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned HOST_AW = 7,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dma_upd_i,
  input  logic [CH_W-1:0]    dma_ch_i,
  input  logic [PTR_W-1:0]   dma_ptr_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [PTR_W-1:0]   host_wdata_i,
  output logic [PTR_W-1:0]   host_rdata_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_CH-1:0] sel;
  logic [NUM_CH-1:0] dma_hit;
  logic [NUM_CH-1:0] ack_hit;
  ptr_t              ptr [NUM_CH];

  cpl_addr_dec #(.NUM_CH(NUM_CH), .HOST_AW(HOST_AW)) u_dec (
    .addr_i (host_addr_i),
    .sel_o  (sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign dma_hit[c] = dma_upd_i && (dma_ch_i == CH_W'(c));
    assign ack_hit[c] = host_we_i && sel[c];

    cpl_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dma_hit_i (dma_hit[c]),
      .dma_ptr_i (dma_ptr_i),
      .ack_hit_i (ack_hit[c]),
      .ack_val_i (host_wdata_i),
      .ptr_o     (ptr[c]),
      .irq_o     (irq_o[c])
    );
  end

  cpl_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
    .sel_i   (sel),
    .ptr_i   (ptr),
    .rdata_o (host_rdata_o)
  );

  AST_ONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_hit)); // R10
  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[1:0] != 2'b00) |-> (host_rdata_o == '0)); // R9
endmodule

// File: tb/sim_cpl_ack_unit.sv
`timescale 1ns/1ps
module sim_cpl_ack_unit;
  localparam int NUM_CH = 8;
  localparam int HOST_AW = 7;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        dma_upd_i = 0;
  logic [2:0]  dma_ch_i = '0;
  logic [31:0] dma_ptr_i = '0;
  logic        host_we_i = 0;
  logic [6:0]  host_addr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic [7:0]  irq_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  cpl_ack_unit #(.NUM_CH(NUM_CH), .HOST_AW(HOST_AW)) u0 (.*);

  typedef struct packed {
    logic        is_ack;
    logic [2:0]  ch;
    logic [31:0] val;
    logic [7:0]  exp_irq;
    logic [31:0] exp_rd;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b0, 3'd0, 32'h0000_1000, 8'h01, 32'h0000_1000},  // R2 R6
    '{1'b0, 3'd3, 32'h0000_2300, 8'h09, 32'h0000_2300},  // R2 R6
    '{1'b1, 3'd3, 32'h0000_2200, 8'h09, 32'h0000_2300},  // R5 R3
    '{1'b1, 3'd3, 32'h0000_2300, 8'h01, 32'h0000_2300},  // R4 R3
    '{1'b0, 3'd7, 32'h0000_7770, 8'h81, 32'h0000_7770},
    '{1'b1, 3'd0, 32'h0000_1000, 8'h80, 32'h0000_1000},  // R4
    '{1'b1, 3'd0, 32'h0000_1000, 8'h80, 32'h0000_1000},  // R8
    '{1'b0, 3'd5, 32'hABCD_0000, 8'hA0, 32'hABCD_0000},
    '{1'b0, 3'd5, 32'hABCD_0010, 8'hA0, 32'hABCD_0010},  // R2
    '{1'b1, 3'd5, 32'hABCD_0000, 8'hA0, 32'hABCD_0010},  // R5
    '{1'b1, 3'd5, 32'hABCD_0010, 8'h80, 32'hABCD_0010},  // R4
    '{1'b1, 3'd7, 32'h0000_7770, 8'h00, 32'h0000_7770}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, returns idle at the following negedge
  task automatic cycle(input logic dv, input logic [2:0] ch, input logic [31:0] dp,
                       input logic hw, input logic [6:0] ha, input logic [31:0] hd);
    @(negedge clk_i);
    dma_upd_i = dv; dma_ch_i = ch; dma_ptr_i = dp;
    host_we_i = hw; host_addr_i = ha; host_wdata_i = hd;
    @(negedge clk_i);
    dma_upd_i = 0; host_we_i = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    host_addr_i = a;
    #1 d = host_rdata_o;
  endtask

  logic [31:0] r;

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 irq", {24'h0, irq_o}, 32'h0);
    for (int c = 0; c < NUM_CH; c++) begin
      rd(7'(c * 4), r);
      check("R1 ptr", r, 32'h0);
    end

    // R8 ack on idle channel with matching value 0
    cycle(0, 0, 0, 1, 7'h04, 32'h0);
    check("R8 irq idle", {24'h0, irq_o}, 32'h0);
    rd(7'h04, r);
    check("R8 ptr", r, 32'h0);

    for (int i = 0; i < 12; i++) begin
      if (TBL[i].is_ack) cycle(0, 0, 0, 1, {2'b0, TBL[i].ch, 2'b00}, TBL[i].val);
      else cycle(1, TBL[i].ch, TBL[i].val, 0, 7'h0, 32'h0);
      check("R4/R5/R6 irq vec", {24'h0, irq_o}, {24'h0, TBL[i].exp_irq});
      rd({2'b0, TBL[i].ch, 2'b00}, r);
      check("R2/R3 ptr vec", r, TBL[i].exp_rd);
    end
    rd(7'h00, r);
    check("R2 other ch kept", r, 32'h0000_1000);

    // R7 DMA and ack same channel, same cycle
    cycle(1, 2, 32'h20, 0, 7'h0, 32'h0);
    cycle(1, 2, 32'h24, 1, 7'h08, 32'h20);
    check("R7 irq", {24'h0, irq_o}, 32'h04);
    rd(7'h08, r);
    check("R7 ptr", r, 32'h24);
    cycle(1, 2, 32'h28, 1, 7'h08, 32'h28);
    check("R7 equal value", {24'h0, irq_o}, 32'h04);
    cycle(0, 0, 0, 1, 7'h08, 32'h28);
    check("R4 after R7", {24'h0, irq_o}, 32'h0);

    // R9 out-of-range and misaligned accesses
    cycle(1, 6, 32'h66, 0, 7'h0, 32'h0);
    cycle(0, 0, 0, 1, 7'h20, 32'h66);
    check("R9 oor write", {24'h0, irq_o}, 32'h40);
    cycle(0, 0, 0, 1, 7'h1A, 32'h66);
    check("R9 misaligned write", {24'h0, irq_o}, 32'h40);
    rd(7'h20, r);
    check("R9 oor read", r, 32'h0);
    rd(7'h19, r);
    check("R9 misaligned read", r, 32'h0);
    rd(7'h18, r);
    check("R9 aligned read", r, 32'h66);

    // R10 same pointer on two channels
    cycle(1, 1, 32'h66, 0, 7'h0, 32'h0);
    cycle(0, 0, 0, 1, 7'h04, 32'h66);
    check("R10 isolation", {24'h0, irq_o}, 32'h40);
    cycle(0, 0, 0, 1, 7'h18, 32'h66);
    check("R10 second clear", {24'h0, irq_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule